// File: doc/BRIEF.md
# Modem Control Input Change Detector

This block conditions the two active-low modem control lines of one serial channel: the clear-to-send line and the carrier-detect line. Both lines pass through a synchronizer into the system clock domain. A level change in either direction on either line sets a sticky change flag, and each flag can drive a shared interrupt through its own enable. From the synchronized levels the block produces a transmitter qualifier and a receiver qualifier, which the serial engines use as enables.

Each line has a second role that the mode inputs select. In loop mode the clear-to-send pin becomes a loop-control output. Only explicit assert and negate commands move that output, and it keeps its level when the mode changes. In character-sync modes, an assertion on the carrier-detect line can be used as an external sync strobe. The strobe gives the receiver character alignment without waiting for a sync character.

Top module: `modem_chg_det`

## Requirements
- R1: While reset is held and just after it, both change flags are 0, `irq` is 0, both level outputs are 0 (inactive), `cts_n_o` is 1 (negated) and `ext_sync_pulse` is 0.
- R2: A pin level shows on `cts_active` / `dcd_active` (1 = pin low) after the second rising clock edge that samples it.
- R3: A change of either synchronized level, in either direction, sets the matching change flag at the next rising edge. The flag then stays 1.
- R4: A 1 on `cts_clr` / `dcd_clr` clears the matching flag at the next edge. If a new change is detected in that same cycle, the flag stays 1.
- R5: `irq` is 1 exactly when (`cts_changed` AND `cts_int_en`) OR (`dcd_changed` AND `dcd_int_en`).
- R6: `tx_enable` equals `cts_active` when `cts_gates_tx`=1 and `loop_mode`=0. In every other case it is 1.
- R7: `rx_enable` equals `dcd_active` when `dcd_gates_rx`=1. Otherwise it is 1.
- R8: While `loop_mode`=1, `cts_oe` is 1 and changes on the clear-to-send input never set `cts_changed`. `cts_oe` is 0 otherwise.
- R9: `loop_assert_cmd` drives `cts_n_o` to 0 and `loop_negate_cmd` drives it to 1, one edge later. When both are given together, assert wins. Without a command, `cts_n_o` holds its value, including across changes of `loop_mode`.
- R10: With `char_sync_mode`=1 and `dcd_as_sync`=1, `ext_sync_pulse` is 1 for exactly the one cycle in which `dcd_active` has just gone from 0 to 1. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, input side (active low) |
| cts_n_o | output | 1 | Loop-control level driven on the clear-to-send pin (active low) |
| cts_oe | output | 1 | Output enable for the clear-to-send pin |
| dcd_n_i | input | 1 | Carrier-detect / external sync pin (active low) |
| loop_mode | input | 1 | Loop mode select |
| cts_gates_tx | input | 1 | Clear-to-send qualifies the transmitter |
| dcd_gates_rx | input | 1 | Carrier-detect qualifies the receiver |
| char_sync_mode | input | 1 | Channel is in a character-oriented sync mode |
| dcd_as_sync | input | 1 | Use carrier-detect assertion as external sync |
| loop_assert_cmd | input | 1 | Command strobe: assert loop-control output |
| loop_negate_cmd | input | 1 | Command strobe: negate loop-control output |
| cts_int_en | input | 1 | Interrupt enable for the clear-to-send change flag |
| dcd_int_en | input | 1 | Interrupt enable for the carrier-detect change flag |
| cts_clr | input | 1 | Write-one-to-clear strobe for the clear-to-send flag |
| dcd_clr | input | 1 | Write-one-to-clear strobe for the carrier-detect flag |
| cts_active | output | 1 | Synchronized clear-to-send level, 1 = asserted |
| dcd_active | output | 1 | Synchronized carrier-detect level, 1 = asserted |
| cts_changed | output | 1 | Sticky clear-to-send change flag |
| dcd_changed | output | 1 | Sticky carrier-detect change flag |
| tx_enable | output | 1 | Transmitter qualifier |
| rx_enable | output | 1 | Receiver qualifier |
| ext_sync_pulse | output | 1 | One-cycle external sync strobe |
| irq | output | 1 | Change interrupt request |

## Verification
The bench aims a clear strobe at the exact cycle in which a new change is detected. A design with the wrong priority loses that event, and the flag reads 0. It toggles the clear-to-send input while loop mode is on. A detector without suppression raises a change interrupt from the pin the block itself drives. It also leaves loop mode after a command and checks that the output level held, which a design that resets the output on a mode change would fail. Finally, it drives carrier-detect in both directions with external sync enabled. Pulses on the negating edge, or pulses longer than one cycle, show up as mismatches against the model.

// File: rtl/modem_chg_det.sv
module modem_chg_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_i,
  output logic cts_n_o,
  output logic cts_oe,
  input  logic dcd_n_i,
  input  logic loop_mode,
  input  logic cts_gates_tx,
  input  logic dcd_gates_rx,
  input  logic char_sync_mode,
  input  logic dcd_as_sync,
  input  logic loop_assert_cmd,
  input  logic loop_negate_cmd,
  input  logic cts_int_en,
  input  logic dcd_int_en,
  input  logic cts_clr,
  input  logic dcd_clr,
  output logic cts_active,
  output logic dcd_active,
  output logic cts_changed,
  output logic dcd_changed,
  output logic tx_enable,
  output logic rx_enable,
  output logic ext_sync_pulse,
  output logic irq
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] cts_sh, dcd_sh;
  logic cts_prev, dcd_prev, loop_q;
  logic cts_edge, dcd_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_sh   <= '1;
      dcd_sh   <= '1;
      cts_prev <= 1'b1;
      dcd_prev <= 1'b1;
    end else begin
      cts_sh   <= {cts_sh[TOP-1:0], cts_n_i};
      dcd_sh   <= {dcd_sh[TOP-1:0], dcd_n_i};
      cts_prev <= cts_sh[TOP];
      dcd_prev <= dcd_sh[TOP];
    end
  end

  assign cts_active = ~cts_sh[TOP];
  assign dcd_active = ~dcd_sh[TOP];
  assign cts_edge   = (cts_sh[TOP] ^ cts_prev) & ~loop_mode;
  assign dcd_edge   = dcd_sh[TOP] ^ dcd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_changed <= 1'b0;
      dcd_changed <= 1'b0;
    end else begin
      cts_changed <= cts_edge | (cts_changed & ~cts_clr);
      dcd_changed <= dcd_edge | (dcd_changed & ~dcd_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               loop_q <= 1'b0;
    else if (loop_assert_cmd) loop_q <= 1'b1;
    else if (loop_negate_cmd) loop_q <= 1'b0;
  end

  assign cts_n_o        = ~loop_q;
  assign cts_oe         = loop_mode;
  assign tx_enable      = loop_mode | ~cts_gates_tx | cts_active;
  assign rx_enable      = ~dcd_gates_rx | dcd_active;
  assign ext_sync_pulse = char_sync_mode & dcd_as_sync & dcd_prev & ~dcd_sh[TOP];
  assign irq            = (cts_changed & cts_int_en) | (dcd_changed & dcd_int_en);

  // R3
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcd_edge |=> dcd_changed);

  // R4
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_clr && !cts_edge) |=> !cts_changed);

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cts_changed || dcd_changed));

  // R8
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |=> !$rose(cts_changed));

  // R9
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_assert_cmd && !loop_negate_cmd) |=> $stable(cts_n_o));

  // R10
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_pulse |=> !ext_sync_pulse);

endmodule

// File: tb/modem_chg_det_tb.sv
module modem_chg_det_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n_i = 1'b1, dcd_n_i = 1'b1;
  logic loop_mode = 0, cts_gates_tx = 0, dcd_gates_rx = 0, char_sync_mode = 0, dcd_as_sync = 0;
  logic loop_assert_cmd = 0, loop_negate_cmd = 0;
  logic cts_int_en = 0, dcd_int_en = 0, cts_clr = 0, dcd_clr = 0;
  logic cts_n_o, cts_oe, cts_active, dcd_active, cts_changed, dcd_changed;
  logic tx_enable, rx_enable, ext_sync_pulse, irq;

  int checks = 0, failures = 0;
  bit done = 0, live = 0;
  int pulses = 0;

  bit hc[$] = '{1, 1, 1};
  bit hd[$] = '{1, 1, 1};
  bit m_cts = 0, m_dcd = 0, m_loop = 0;

  always #2.5 clk = ~clk;

  modem_chg_det u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n_i), .cts_n_o(cts_n_o), .cts_oe(cts_oe),
    .dcd_n_i(dcd_n_i), .loop_mode(loop_mode), .cts_gates_tx(cts_gates_tx),
    .dcd_gates_rx(dcd_gates_rx), .char_sync_mode(char_sync_mode), .dcd_as_sync(dcd_as_sync),
    .loop_assert_cmd(loop_assert_cmd), .loop_negate_cmd(loop_negate_cmd),
    .cts_int_en(cts_int_en), .dcd_int_en(dcd_int_en), .cts_clr(cts_clr), .dcd_clr(dcd_clr),
    .cts_active(cts_active), .dcd_active(dcd_active), .cts_changed(cts_changed),
    .dcd_changed(dcd_changed), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .ext_sync_pulse(ext_sync_pulse), .irq(irq));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '{1, 1, 1}; hd = '{1, 1, 1};
      m_cts = 0; m_dcd = 0; m_loop = 0; live = 0;
    end else begin
      bit ce, de;
      ce = (hc[1] != hc[0]) && !loop_mode;
      de = (hd[1] != hd[0]);
      m_cts = ce ? 1'b1 : (cts_clr ? 1'b0 : m_cts);
      m_dcd = de ? 1'b1 : (dcd_clr ? 1'b0 : m_dcd);
      if (loop_assert_cmd) m_loop = 1;
      else if (loop_negate_cmd) m_loop = 0;
      hc.push_back(cts_n_i); void'(hc.pop_front());
      hd.push_back(dcd_n_i); void'(hd.pop_front());
      live = 1;
    end
  end

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      chk("R2 cts_active", cts_active, !hc[1]);
      chk("R2 dcd_active", dcd_active, !hd[1]);
      chk("R3 cts_changed", cts_changed, m_cts);
      chk("R3 dcd_changed", dcd_changed, m_dcd);
      chk("R5 irq", irq, (m_cts && cts_int_en) || (m_dcd && dcd_int_en));
      chk("R6 tx_enable", tx_enable, loop_mode || !cts_gates_tx || !hc[1]);
      chk("R7 rx_enable", rx_enable, !dcd_gates_rx || !hd[1]);
      chk("R8 cts_oe", cts_oe, loop_mode);
      chk("R9 cts_n_o", cts_n_o, !m_loop);
      chk("R10 ext_sync_pulse", ext_sync_pulse,
          char_sync_mode && dcd_as_sync && hd[0] && !hd[1]);
      if (ext_sync_pulse) pulses++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
    end
  end

  initial begin
    tick(3);
    // R1 during reset
    chk("R1 cts_changed", cts_changed, 0);
    chk("R1 dcd_changed", dcd_changed, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cts_n_o", cts_n_o, 1);
    chk("R1 cts_active", cts_active, 0);
    chk("R1 ext_sync", ext_sync_pulse, 0);
    rst_n = 1;
    tick(2);
    chk("R1 dcd_active", dcd_active, 0);

    cts_int_en = 1; dcd_int_en = 1; cts_gates_tx = 1; dcd_gates_rx = 1;
    cts_n_i = 0; tick(4);
    chk("R3 cts flag after fall", cts_changed, 1);
    chk("R5 irq after cts change", irq, 1);
    cts_clr = 1; tick(); cts_clr = 0; tick();
    chk("R4 cts cleared", cts_changed, 0);

    // clear in the same cycle as a new edge
    cts_n_i = 1; tick(); tick();
    cts_clr = 1; tick(); cts_clr = 0; tick();
    chk("R4 edge beats clear", cts_changed, 1);
    cts_clr = 1; tick(); cts_clr = 0;

    // loop mode suppresses detection and drives the pin
    loop_mode = 1; tick();
    cts_n_i = 0; tick(3); cts_n_i = 1; tick(4);
    chk("R8 no flag in loop", cts_changed, 0);
    chk("R8 oe in loop", cts_oe, 1);
    loop_assert_cmd = 1; tick(); loop_assert_cmd = 0; tick();
    chk("R9 loop asserted", cts_n_o, 0);
    loop_mode = 0; tick(3);
    chk("R9 holds after mode exit", cts_n_o, 0);
    loop_assert_cmd = 1; loop_negate_cmd = 1; tick(); loop_assert_cmd = 0; loop_negate_cmd = 0; tick();
    chk("R9 assert wins", cts_n_o, 0);
    loop_negate_cmd = 1; tick(); loop_negate_cmd = 0; tick();
    chk("R9 negated", cts_n_o, 1);

    // external sync
    char_sync_mode = 1; dcd_as_sync = 1; pulses = 0;
    dcd_n_i = 0; tick(6); dcd_n_i = 1; tick(6);
    chk("R10 one pulse per assertion", pulses == 1, 1);
    chk("R7 rx gated by dcd", rx_enable, 0);

    for (int i = 0; i < 4000; i++) begin
      cts_n_i = ($urandom % 5 == 0) ? ~cts_n_i : cts_n_i;
      dcd_n_i = ($urandom % 5 == 0) ? ~dcd_n_i : dcd_n_i;
      cts_clr = ($urandom % 4 == 0);
      dcd_clr = ($urandom % 4 == 0);
      loop_assert_cmd = ($urandom % 10 == 0);
      loop_negate_cmd = ($urandom % 10 == 0);
      if (i % 50 == 0) begin
        loop_mode = $urandom; cts_gates_tx = $urandom; dcd_gates_rx = $urandom;
        char_sync_mode = $urandom; dcd_as_sync = $urandom;
        cts_int_en = $urandom; dcd_int_en = $urandom;
      end
      tick();
    end
    tick(2);
    done = 1;
    summary();
  end
endmodule